// File: doc/BRIEF.md
# Hardware Loop Iteration Counter

This block keeps the remaining iteration count of a zero-overhead hardware loop. The surrounding sequencer loads the count from a 16-bit data bus before entering a loop. It raises a test strobe each time it evaluates the end-of-loop condition, and it pushes and pops the count when loops nest. The block reports a counter-expired flag that the condition logic reads at the start of a cycle. The count itself is decremented at the end of that same cycle.

The value loaded is the true iteration count N. The expired flag is high while the count equals 1. The test sees the flag before the decrement takes effect, so a loop that leaves when the flag is seen runs its body exactly N times. A small last-in first-out count stack keeps the outer loop's count while an inner loop runs. Two sticky flags record a push onto a full stack and a pop from an empty stack.

Top module: `lc_loop_counter`

## Requirements
- R1: After synchronous reset the count is 0, the stack depth is 0, and the expired, overflow and underflow flags are all low.
- R2: A load takes bits [13:0] of the 16-bit bus as the new count, unchanged, one cycle later. Bits [15:14] are ignored.
- R3: The expired output is high exactly while the count register equals 1.
- R4: A test strobe with no load and no valid pop lowers the count by one. After a load of N, the expired flag is first seen high on the N-th test, and the count is 0 after that test.
- R5: A test strobe while the count is 0 wraps the count to 16383 (all 14 bits set), and the expired flag stays low.
- R6: When load and test strobe come in the same cycle, the loaded value is taken and no decrement is applied.
- R7: A push stores the count held at the start of that cycle on top of the stack. A valid pop restores the most recently pushed count and takes priority over a test strobe in the same cycle. A load in the same cycle as a valid pop sets the count to the loaded value, and the pop still removes the top entry.
- R8: A push while the stack holds 4 entries sets the sticky overflow flag and leaves the stack contents and depth unchanged. The 4 stored counts are later popped intact, in reverse order.
- R9: A pop while the stack is empty sets the sticky underflow flag and leaves the count and depth unchanged.
- R10: When push and pop are requested in the same cycle, the push is performed and the pop is ignored.
- R11: The depth output gives the number of stored entries (0 to 4). It rises by one on each accepted push and falls by one on each accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load the count from the bus |
| bus_i | input | 16 | Data bus; the low 14 bits carry the count |
| test_i | input | 1 | Loop-end test using the expired condition; requests the decrement |
| push_i | input | 1 | Save the current count on the stack |
| pop_i | input | 1 | Restore the most recently saved count |
| count_o | output | 14 | Current count |
| expired_o | output | 1 | Counter-expired status |
| depth_o | output | 3 | Number of stack entries in use |
| ovf_o | output | 1 | Sticky stack overflow flag |
| udf_o | output | 1 | Sticky stack underflow flag |

## Verification
The hardest situation to reach is an overflowing push that must leave all four stored counts untouched. Reaching it takes five nested push-and-load steps, each with a distinct count. The stimulus then pops four times and compares each restored value against the order in which the counts were pushed, with the overflow flag still high. Exact iteration counts are checked by a loop that samples the expired flag before each test strobe, the way the condition logic would, and counts the iterations until that sample is seen high.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int LC_CNT_W     = 14;
    localparam int LC_BUS_W     = 16;
    localparam int LC_STK_DEPTH = 4;

    // source of the next count value
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_LOAD = 2'd1,
        SRC_POP  = 2'd2,
        SRC_DEC  = 2'd3
    } lc_src_e;

    // resolved stack operation for one cycle
    typedef struct packed {
        logic do_push;
        logic do_pop;
        logic ovf_evt;
        logic udf_evt;
    } lc_stk_op_t;

    // load beats a pop, a pop beats a decrement
    function automatic lc_src_e lc_pick_src(input logic load, input logic pop_ok,
                                            input logic test);
        if (load)        return SRC_LOAD;
        else if (pop_ok) return SRC_POP;
        else if (test)   return SRC_DEC;
        else             return SRC_HOLD;
    endfunction

    // push wins over pop; errors when the stack cannot serve the request
    function automatic lc_stk_op_t lc_resolve_stk(input logic push, input logic pop,
                                                  input logic full, input logic empty);
        lc_stk_op_t op;
        op.do_push = push && !full;
        op.ovf_evt = push && full;
        op.do_pop  = pop && !push && !empty;
        op.udf_evt = pop && !push && empty;
        return op;
    endfunction

endpackage

// File: rtl/lc_sticky.sv
module lc_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
    end

    assert_sticky_hold_R8_R9: assert property (@(posedge clk) disable iff (rst)
        flag_o |=> flag_o);
endmodule

// File: rtl/lc_count_stack.sv
module lc_count_stack
    import lc_pkg::*;
#(
    parameter int W     = LC_CNT_W,
    parameter int DEPTH = LC_STK_DEPTH,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  din_i,
    output logic [W-1:0]  top_o,
    output logic [PW-1:0] depth_o,
    output logic          pop_ok_o,
    output logic          ovf_evt_o,
    output logic          udf_evt_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] depth_q;
    logic          full, empty;
    lc_stk_op_t    op;

    assign full  = (depth_q == PW'(DEPTH));
    assign empty = (depth_q == '0);
    assign op    = lc_resolve_stk(push_i, pop_i, full, empty);

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (op.do_push && depth_q == PW'(g))
                    mem[g] <= din_i;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)             depth_q <= '0;
        else if (op.do_push) depth_q <= depth_q + 1'b1;
        else if (op.do_pop)  depth_q <= depth_q - 1'b1;
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth_q == PW'(i + 1)) top_o = mem[i];
        end
    end

    assign depth_o   = depth_q;
    assign pop_ok_o  = op.do_pop;
    assign ovf_evt_o = op.ovf_evt;
    assign udf_evt_o = op.udf_evt;

    // R11: accepted push grows the depth by one
    assert_push_depth_R11: assert property (@(posedge clk) disable iff (rst)
        (push_i && depth_q < PW'(DEPTH)) |=> depth_q == $past(depth_q) + 1'b1);
    // R8: push on a full stack keeps the depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (push_i && depth_q == PW'(DEPTH)) |=> depth_q == PW'(DEPTH));
    // R9: pop on an empty stack keeps the depth at zero
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && depth_q == '0) |=> depth_q == '0);
    // R11: depth never exceeds capacity
    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (rst)
        depth_q <= PW'(DEPTH));
endmodule

// File: rtl/lc_count_core.sv
module lc_count_core
    import lc_pkg::*;
#(
    parameter int W = LC_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         pop_ok_i,
    input  logic [W-1:0] pop_val_i,
    input  logic         test_i,
    output logic [W-1:0] count_o,
    output logic         expired_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, cnt_d;
    lc_src_e      src;

    assign src = lc_pick_src(load_i, pop_ok_i, test_i);

    always_comb begin
        unique case (src)
            SRC_LOAD: cnt_d = load_val_i;
            SRC_POP:  cnt_d = pop_val_i;
            SRC_DEC:  cnt_d = cnt_q - ONE;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // flag is read before the decrement of the same cycle
    assign expired_o = (cnt_q == ONE);
    assign count_o   = cnt_q;

    // R2: a load lands one cycle later
    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == $past(load_val_i));
    // R4: a test on an expired count leaves zero
    assert_expire_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (test_i && !load_i && !pop_ok_i && expired_o) |=> cnt_q == '0);
    // R5: decrement from zero wraps to all ones without expiry
    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (test_i && !load_i && !pop_ok_i && cnt_q == '0) |=> (cnt_q == '1 && !expired_o));
    // R7: a valid pop without load restores the stack top
    assert_pop_restore_R7: assert property (@(posedge clk) disable iff (rst)
        (pop_ok_i && !load_i) |=> cnt_q == $past(pop_val_i));
    // R4: idle cycles hold the count
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !pop_ok_i && !test_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lc_loop_counter.sv
module lc_loop_counter
    import lc_pkg::*;
#(
    parameter int CNT_W     = LC_CNT_W,
    parameter int BUS_W     = LC_BUS_W,
    parameter int STK_DEPTH = LC_STK_DEPTH,
    localparam int DW       = $clog2(STK_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic             test_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expired_o,
    output logic [DW-1:0]    depth_o,
    output logic             ovf_o,
    output logic             udf_o
);
    logic [CNT_W-1:0] count_w, top_w;
    logic             pop_ok, ovf_evt, udf_evt;

    lc_count_stack #(.W(CNT_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .din_i     (count_w),
        .top_o     (top_w),
        .depth_o   (depth_o),
        .pop_ok_o  (pop_ok),
        .ovf_evt_o (ovf_evt),
        .udf_evt_o (udf_evt)
    );

    lc_count_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .load_val_i (bus_i[CNT_W-1:0]),
        .pop_ok_i   (pop_ok),
        .pop_val_i  (top_w),
        .test_i     (test_i),
        .count_o    (count_w),
        .expired_o  (expired_o)
    );

    lc_sticky u_ovf (.clk(clk), .rst(rst), .set_i(ovf_evt), .flag_o(ovf_o));
    lc_sticky u_udf (.clk(clk), .rst(rst), .set_i(udf_evt), .flag_o(udf_o));

    assign count_o = count_w;

    // R6: load beats decrement
    assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (load_i && test_i) |=> count_o == $past(bus_i[CNT_W-1:0]));
    // R9: pop from empty leaves the count alone when nothing else acts
    assert_udf_count_R9: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !load_i && !test_i && depth_o == '0) |=> $stable(count_o));
    // R10: push with pop grows the stack
    assert_push_over_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && depth_o < DW'(STK_DEPTH)) |=> depth_o == $past(depth_o) + 1'b1);
endmodule

// File: tb/tb_lc_loop_counter.sv
module tb_lc_loop_counter;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_i, test_i, push_i, pop_i;
    logic [15:0] bus_i;
    logic [13:0] count_o;
    logic        expired_o, ovf_o, udf_o;
    logic [2:0]  depth_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    lc_loop_counter dut (
        .clk(clk), .rst(rst), .load_i(load_i), .bus_i(bus_i), .test_i(test_i),
        .push_i(push_i), .pop_i(pop_i), .count_o(count_o), .expired_o(expired_o),
        .depth_o(depth_o), .ovf_o(ovf_o), .udf_o(udf_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of stimulus; outputs valid on return
    task automatic step(input logic ld, input logic [15:0] d, input logic t,
                        input logic pu, input logic po);
        @(negedge clk);
        load_i = ld; bus_i = d; test_i = t; push_i = pu; pop_i = po;
        @(posedge clk);
        #1;
        load_i = 0; test_i = 0; push_i = 0; pop_i = 0; bus_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; load_i = 0; test_i = 0; push_i = 0; pop_i = 0; bus_i = '0;
        @(posedge clk); @(posedge clk);
        #1; rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count_o, 0);
        chk("R1 depth", depth_o, 0);
        chk("R1 expired", expired_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 udf", udf_o, 0);
    endtask

    task automatic t_load();
        do_reset();
        step(1, 16'hC005, 0, 0, 0);
        chk("R2 low bits", count_o, 5);
        step(1, 16'h3FFE, 0, 0, 0);
        chk("R2 full width", count_o, 16382);
        step(1, 16'h4001, 0, 0, 0);
        chk("R3 expired at 1", expired_o, 1);
        step(1, 16'h0002, 0, 0, 0);
        chk("R3 not expired at 2", expired_o, 0);
    endtask

    task automatic t_loop(input int n);
        int  iters = 0;
        logic seen;
        do_reset();
        step(1, 16'(n), 0, 0, 0);
        do begin
            iters++;
            seen = expired_o;
            step(0, '0, 1, 0, 0);
        end while (!seen && iters < 100);
        chk($sformatf("R4 iterations N=%0d", n), iters, n);
        chk("R4 count after exit", count_o, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        chk("R5 expired at 0", expired_o, 0);
        step(0, '0, 1, 0, 0);
        chk("R5 wrap value", count_o, 16383);
        chk("R5 no expiry", expired_o, 0);
    endtask

    task automatic t_priority();
        do_reset();
        step(1, 16'd5, 0, 0, 0);
        step(1, 16'd9, 1, 0, 0);
        chk("R6 load over test", count_o, 9);
        step(1, 16'd7, 0, 0, 0);
        step(1, 16'd2, 0, 1, 0);
        chk("R7 push depth", depth_o, 1);
        chk("R7 inner count", count_o, 2);
        step(0, '0, 1, 0, 1);
        chk("R7 pop over test", count_o, 7);
        chk("R7 pop depth", depth_o, 0);
        step(1, 16'd3, 0, 1, 0);
        step(1, 16'd4, 0, 0, 1);
        chk("R7 load over pop count", count_o, 4);
        chk("R7 load with pop depth", depth_o, 0);
    endtask

    task automatic t_push_pop();
        do_reset();
        step(1, 16'd11, 0, 0, 0);
        step(0, '0, 0, 1, 1);
        chk("R10 push wins depth", depth_o, 1);
        chk("R10 count unchanged", count_o, 11);
        step(1, 16'd20, 0, 0, 0);
        step(0, '0, 0, 0, 1);
        chk("R10 pushed value", count_o, 11);
        chk("R11 depth back to 0", depth_o, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        step(1, 16'd10, 0, 0, 0);
        for (int k = 2; k <= 5; k++) step(1, 16'(k * 10), 0, 1, 0);
        chk("R11 depth full", depth_o, 4);
        chk("R8 no ovf yet", ovf_o, 0);
        step(1, 16'd60, 0, 1, 0);
        chk("R8 ovf set", ovf_o, 1);
        chk("R8 depth kept", depth_o, 4);
        for (int k = 4; k >= 1; k--) begin
            step(0, '0, 0, 0, 1);
            chk($sformatf("R8 restored entry %0d", k), count_o, k * 10);
        end
        chk("R8 ovf sticky", ovf_o, 1);
        chk("R8 no udf", udf_o, 0);
    endtask

    task automatic t_underflow();
        do_reset();
        step(1, 16'd8, 0, 0, 0);
        step(0, '0, 0, 0, 1);
        chk("R9 udf set", udf_o, 1);
        chk("R9 count kept", count_o, 8);
        chk("R9 depth kept", depth_o, 0);
        step(0, '0, 0, 0, 0);
        chk("R9 udf sticky", udf_o, 1);
    endtask

    initial begin
        rst = 1; load_i = 0; test_i = 0; push_i = 0; pop_i = 0; bus_i = '0;
        t_reset();
        t_load();
        t_loop(1);
        t_loop(3);
        t_loop(7);
        t_wrap();
        t_priority();
        t_push_pop();
        t_overflow();
        t_underflow();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule